// File: doc/BRIEF.md
# EEPROM Program/Erase Sequencer

This block is the control logic that sits beside a byte-wide on-chip EEPROM array. Software arms the array through a program-control register, stores one address/data pair by writing to the array or to the configuration register, then raises the high-voltage enable. It keeps that enable on for a minimum number of cycles and finally drops it. The falling enable commits the stored operation. The operation is one of four: a bit-clearing program, a single-byte erase, an erase of a 16-byte aligned row, or an erase of the whole array.

The array holds one extra byte past its last addressable cell. This byte is the configuration byte. The memory port cannot reach it, but a write to the configuration register address stores into it. On each reset the live configuration register is reloaded from that hidden byte. One bit of the reloaded value decides whether the array appears on the memory port at all. A newly programmed configuration therefore takes effect only after the next reset.

Protocol mistakes do not stop the block. Each one raises a one-cycle error pulse that carries a code naming the mistake.

Top module: `eeprom_seq_ctrl`

## Requirements
- R1: After `rst_n` the control register reads 0 and nothing is latched. `cfg_q` holds the stored configuration byte. `mem_mapped` equals bit `CFG_EN_BIT` (bit 0) of that byte. `pwr_rst_n` sets every cell, including the configuration byte, to 0xFF.
- R2: The control register bits are: bit 0 high-voltage enable, bit 1 latch enable, bit 2 erase, bit 3 row, bit 4 byte. Bits 7:5 always read 0. A control write whose bit 1 is 0 stores 0 in the whole register.
- R3: A control write that sets bits 1 and 0 together while both are currently 0 is rejected. It leaves the register unchanged and gives error code 1. Clearing both bits in one write is legal.
- R4: Setting the high-voltage enable while no address/data pair is latched gives error code 2. The write still takes effect, and the later fall commits nothing.
- R5: The hold time is the number of clock edges from the write that sets the high-voltage enable to the write that clears it. A hold shorter than `HOLD_MIN` gives error code 3 on the clearing write, and the commit still happens. A hold of exactly `HOLD_MIN` gives no error.
- R6: A data write while latch enable is 0 gives error code 4 and latches nothing. A second data write while a pair is already latched gives error code 5 and keeps the first pair. Every commit empties the latch.
- R7: An array read while latch enable is 1 gives error code 6. The read still returns the cell contents.
- R8: A commit with erase off sets the latched cell to its old value AND the latched data.
- R9: A commit with erase on and byte on sets only the latched cell to 0xFF.
- R10: A commit with erase on, byte off and row on sets the 16-byte row containing the latched address, aligned down, to 0xFF.
- R11: A commit with erase on and both byte and row off sets every cell to 0xFF, the configuration byte included.
- R12: A configuration-register write latches the hidden byte's address. An erase commit at that address touches only that byte, whatever the row and byte bits say. `cfg_q` changes only at reset.
- R13: While the array is unmapped, array reads return 0 and array writes are ignored without error.
- R14: An error appears on `err_valid`/`err_code` in the cycle after the access that caused it and lasts one cycle. When more than one error applies, codes 1, 2, 3, 4, 5, 6 take priority in that order.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| pwr_rst_n | input | 1 | Power-on reset, active low, synchronous; fills the array with 0xFF |
| rst_n | input | 1 | Controller reset, active low, synchronous; reloads configuration |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 1 | 0 selects the control register, 1 the configuration register |
| reg_wdata | input | 8 | Register write data |
| ctrl_q | output | 8 | Control register contents |
| cfg_q | output | 8 | Live configuration register |
| mem_we | input | 1 | Array write strobe |
| mem_re | input | 1 | Array read strobe |
| mem_addr | input | ADDR_W | Array byte address |
| mem_wdata | input | 8 | Array write data |
| mem_rdata | output | 8 | Array read data (combinational) |
| mem_mapped | output | 1 | Array visible on the memory port |
| err_valid | output | 1 | One-cycle protocol error pulse |
| err_code | output | 3 | Error code, 0 when none |

## Verification
The hardest case to reach is the hidden configuration byte. The memory port never shows it, so its value can only be seen indirectly: the bench programs or erases it through the configuration register, pulses `rst_n`, and then observes `cfg_q`, `mem_mapped` and the memory port. With that sequence it checks three things. A programmed value is deferred until reset. An erase aimed at that byte leaves the other cells alone. A bulk erase restores the byte, and with it the array mapping. The hold window is checked at both HOLD_MIN-1 and HOLD_MIN edges, with the bench's own cycle count setting the gap between the two control writes.

// File: rtl/eeprom_seq_pkg.sv
package eeprom_seq_pkg;

  // control register bit positions
  localparam int CB_PGM   = 0;
  localparam int CB_LAT   = 1;
  localparam int CB_ERASE = 2;
  localparam int CB_ROW   = 3;
  localparam int CB_BYTE  = 4;
  localparam logic [7:0] CTRL_MASK = 8'h1F;

  typedef enum logic [2:0] {
    ERR_NONE         = 3'd0,
    ERR_BOTH_ON      = 3'd1,
    ERR_PGM_NO_ADDR  = 3'd2,
    ERR_SHORT_HOLD   = 3'd3,
    ERR_NOT_ARMED    = 3'd4,
    ERR_DOUBLE_LATCH = 3'd5,
    ERR_READ_ARMED   = 3'd6
  } err_code_e;

  typedef enum logic [1:0] {
    OP_PROGRAM    = 2'd0,
    OP_ERASE_BYTE = 2'd1,
    OP_ERASE_ROW  = 2'd2,
    OP_ERASE_BULK = 2'd3
  } commit_op_e;

  typedef enum logic {
    LS_EMPTY = 1'b0,
    LS_HELD  = 1'b1
  } latch_state_e;

  // latch enable and voltage enable both switched on from all-off
  function automatic logic both_rising(logic [7:0] cur, logic [7:0] wr);
    return !cur[CB_LAT] && !cur[CB_PGM] && wr[CB_LAT] && wr[CB_PGM];
  endfunction

  // value stored by an accepted control write
  function automatic logic [7:0] filter_ctrl(logic [7:0] wr);
    return wr[CB_LAT] ? (wr & CTRL_MASK) : 8'h00;
  endfunction

  // operation selected by the mode bits that were in force before the commit
  function automatic commit_op_e pick_op(logic [7:0] cur, logic at_cfg);
    if (!cur[CB_ERASE])                return OP_PROGRAM;
    else if (cur[CB_BYTE] || at_cfg)   return OP_ERASE_BYTE;
    else if (cur[CB_ROW])              return OP_ERASE_ROW;
    else                               return OP_ERASE_BULK;
  endfunction

  // new contents of one cell for a given commit
  function automatic logic [7:0] cell_after(logic [7:0] old, commit_op_e op,
                                            logic hit_byte, logic hit_row,
                                            logic [7:0] ldata);
    case (op)
      OP_PROGRAM:    return hit_byte ? (old & ldata) : old;
      OP_ERASE_BYTE: return hit_byte ? 8'hFF : old;
      OP_ERASE_ROW:  return hit_row  ? 8'hFF : old;
      default:       return 8'hFF;
    endcase
  endfunction

endpackage

// File: rtl/eeprom_hv_timer.sv
module eeprom_hv_timer #(
  parameter int HOLD_MIN = 10000,
  localparam int CNT_W = $clog2(HOLD_MIN) + 1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic run,
  output logic hold_short
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(HOLD_MIN - 1);

  logic [CNT_W-1:0] cnt;

  // cnt equals edges-since-restart minus one; saturates once the window is met
  always_ff @(posedge clk) begin
    if (!rst_n)                 cnt <= '0;
    else if (restart)           cnt <= '0;
    else if (run && cnt != SAT) cnt <= cnt + 1'b1;
  end

  assign hold_short = (cnt < SAT);
endmodule

// File: rtl/eeprom_prog_ctrl.sv
module eeprom_prog_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int IDX_W   = 7,
  parameter int CFG_IDX = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_wr,
  input  logic [7:0]       ctrl_wdata,
  input  logic             data_wr,
  input  logic [IDX_W-1:0] data_idx,
  input  logic [7:0]       data_val,
  input  logic             rd_req,
  input  logic             hold_short,
  output logic [7:0]       ctrl_q,
  output logic             lat_held,
  output logic [IDX_W-1:0] lat_idx,
  output logic [7:0]       lat_val,
  output logic             commit_evt,
  output commit_op_e       commit_op,
  output logic             both_rise,
  output logic             timer_restart,
  output logic             timer_run,
  output logic             err_valid,
  output logic [2:0]       err_code
);
  latch_state_e lstate;
  err_code_e    err_next;
  logic [7:0]   ctrl_new;
  logic         accept_ctrl, pgm_on_wr, pgm_fall, arm_ok;

  assign both_rise   = ctrl_wr && both_rising(ctrl_q, ctrl_wdata);
  assign ctrl_new    = filter_ctrl(ctrl_wdata);
  assign accept_ctrl = ctrl_wr && !both_rise;
  assign pgm_on_wr   = accept_ctrl && ctrl_new[CB_PGM];
  assign pgm_fall    = accept_ctrl && ctrl_q[CB_PGM] && !ctrl_new[CB_PGM];
  assign lat_held    = (lstate == LS_HELD);
  assign commit_evt  = pgm_fall && lat_held;
  assign commit_op   = pick_op(ctrl_q, lat_idx == IDX_W'(CFG_IDX));
  assign arm_ok      = data_wr && ctrl_q[CB_LAT] && !lat_held;

  assign timer_restart = pgm_on_wr;
  assign timer_run     = ctrl_q[CB_PGM];

  always_comb begin
    if (both_rise)                        err_next = ERR_BOTH_ON;
    else if (pgm_on_wr && !lat_held)      err_next = ERR_PGM_NO_ADDR;
    else if (pgm_fall && hold_short)      err_next = ERR_SHORT_HOLD;
    else if (data_wr && !ctrl_q[CB_LAT])  err_next = ERR_NOT_ARMED;
    else if (data_wr && lat_held)         err_next = ERR_DOUBLE_LATCH;
    else if (rd_req && ctrl_q[CB_LAT])    err_next = ERR_READ_ARMED;
    else                                  err_next = ERR_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_q    <= 8'h00;
      lstate    <= LS_EMPTY;
      lat_idx   <= '0;
      lat_val   <= 8'h00;
      err_valid <= 1'b0;
      err_code  <= 3'd0;
    end else begin
      if (accept_ctrl) ctrl_q <= ctrl_new;
      if (commit_evt) begin
        lstate <= LS_EMPTY;
      end else if (arm_ok) begin
        lstate  <= LS_HELD;
        lat_idx <= data_idx;
        lat_val <= data_val;
      end
      err_valid <= (err_next != ERR_NONE);
      err_code  <= err_next;
    end
  end
endmodule

// File: rtl/eeprom_cell_array.sv
module eeprom_cell_array
  import eeprom_seq_pkg::*;
#(
  parameter int ARRAY_BYTES = 64,
  parameter int ROW_BYTES   = 16,
  localparam int ADDR_W = $clog2(ARRAY_BYTES),
  localparam int IDX_W  = $clog2(ARRAY_BYTES + 1)
) (
  input  logic             clk,
  input  logic             pwr_rst_n,
  input  logic             commit,
  input  commit_op_e       op,
  input  logic [IDX_W-1:0] lat_idx,
  input  logic [7:0]       lat_val,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [7:0]       rd_data,
  output logic [7:0]       cfg_byte
);
  localparam int CELLS     = ARRAY_BYTES + 1;
  localparam int ROW_SHIFT = $clog2(ROW_BYTES);

  logic [7:0] cells [CELLS];

  function automatic logic [IDX_W-1:0] row_of(logic [IDX_W-1:0] idx);
    return idx >> ROW_SHIFT;
  endfunction

  always_ff @(posedge clk) begin
    for (int i = 0; i < CELLS; i++) begin
      if (!pwr_rst_n)
        cells[i] <= 8'hFF;
      else if (commit)
        cells[i] <= cell_after(cells[i], op,
                               lat_idx == IDX_W'(i),
                               row_of(IDX_W'(i)) == row_of(lat_idx),
                               lat_val);
    end
  end

  assign rd_data  = cells[IDX_W'(rd_addr)];
  assign cfg_byte = cells[ARRAY_BYTES];
endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_seq_pkg::*;
#(
  parameter int ARRAY_BYTES = 64,
  parameter int ROW_BYTES   = 16,
  parameter int HOLD_MIN    = 10000,
  parameter int CFG_EN_BIT  = 0,
  localparam int ADDR_W = $clog2(ARRAY_BYTES)
) (
  input  logic              clk,
  input  logic              pwr_rst_n,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_sel,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        ctrl_q,
  output logic [7:0]        cfg_q,
  input  logic              mem_we,
  input  logic              mem_re,
  input  logic [ADDR_W-1:0] mem_addr,
  input  logic [7:0]        mem_wdata,
  output logic [7:0]        mem_rdata,
  output logic              mem_mapped,
  output logic              err_valid,
  output logic [2:0]        err_code
);
  localparam int IDX_W = $clog2(ARRAY_BYTES + 1);

  logic             ctl_rst_n, ctrl_wr, cfg_wr, data_wr, rd_req;
  logic [IDX_W-1:0] data_idx, lat_idx;
  logic [7:0]       data_val, lat_val, arr_rd, cfg_byte;
  logic             lat_held, commit_evt, both_rise, hold_short;
  logic             timer_restart, timer_run;
  commit_op_e       commit_op;

  assign ctl_rst_n = rst_n && pwr_rst_n;
  assign ctrl_wr   = reg_we && !reg_sel;
  assign cfg_wr    = reg_we && reg_sel;
  assign data_wr   = cfg_wr || (mem_we && mem_mapped);
  assign data_idx  = cfg_wr ? IDX_W'(ARRAY_BYTES) : IDX_W'(mem_addr);
  assign data_val  = cfg_wr ? reg_wdata : mem_wdata;
  assign rd_req    = mem_re && mem_mapped;

  eeprom_prog_ctrl #(.IDX_W(IDX_W), .CFG_IDX(ARRAY_BYTES)) u_ctrl (
    .clk(clk), .rst_n(ctl_rst_n),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(reg_wdata),
    .data_wr(data_wr), .data_idx(data_idx), .data_val(data_val),
    .rd_req(rd_req), .hold_short(hold_short),
    .ctrl_q(ctrl_q), .lat_held(lat_held), .lat_idx(lat_idx), .lat_val(lat_val),
    .commit_evt(commit_evt), .commit_op(commit_op), .both_rise(both_rise),
    .timer_restart(timer_restart), .timer_run(timer_run),
    .err_valid(err_valid), .err_code(err_code)
  );

  eeprom_hv_timer #(.HOLD_MIN(HOLD_MIN)) u_timer (
    .clk(clk), .rst_n(ctl_rst_n),
    .restart(timer_restart), .run(timer_run), .hold_short(hold_short)
  );

  eeprom_cell_array #(.ARRAY_BYTES(ARRAY_BYTES), .ROW_BYTES(ROW_BYTES)) u_cells (
    .clk(clk), .pwr_rst_n(pwr_rst_n),
    .commit(commit_evt), .op(commit_op),
    .lat_idx(lat_idx), .lat_val(lat_val),
    .rd_addr(mem_addr), .rd_data(arr_rd), .cfg_byte(cfg_byte)
  );

  // live configuration: reloaded from the hidden byte only while in reset
  always_ff @(posedge clk) begin
    if (!pwr_rst_n) begin
      cfg_q      <= 8'hFF;
      mem_mapped <= 1'b1;
    end else if (!rst_n) begin
      cfg_q      <= cfg_byte;
      mem_mapped <= cfg_byte[CFG_EN_BIT];
    end
  end

  assign mem_rdata = mem_mapped ? arr_rd : 8'h00;
endmodule

// File: rtl/eeprom_seq_ctrl_chk.sv
module eeprom_seq_ctrl_chk
  import eeprom_seq_pkg::*;
(
  input logic       clk,
  input logic       pwr_rst_n,
  input logic       rst_n,
  input logic [7:0] ctrl_q,
  input logic [7:0] cfg_q,
  input logic       err_valid,
  input logic [2:0] err_code,
  input logic       commit_evt,
  input logic       lat_held,
  input logic       both_rise,
  input logic       hold_short
);
  // R3
  both_on_reject_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_rst_n)
    both_rise |=> ($stable(ctrl_q) && err_valid && err_code == 3'd1));

  // R5
  commit_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_rst_n)
    commit_evt |-> ctrl_q[CB_PGM]);

  // R5
  full_hold_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_rst_n)
    (commit_evt && !hold_short) |=> !err_valid);

  // R6
  latch_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_rst_n)
    $rose(lat_held) |-> $past(ctrl_q[CB_LAT]));

  // R6
  commit_empties_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_rst_n)
    commit_evt |=> !lat_held);

  // R12
  cfg_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_rst_n)
    1'b1 |=> $stable(cfg_q));

  // R2
  ctrl_shape_chk: assert property (@(posedge clk) disable iff (!rst_n || !pwr_rst_n)
    (ctrl_q[7:5] == 3'b000) && (ctrl_q[CB_LAT] || ctrl_q == 8'h00));
endmodule

bind eeprom_seq_ctrl eeprom_seq_ctrl_chk u_chk (
  .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n),
  .ctrl_q(ctrl_q), .cfg_q(cfg_q),
  .err_valid(err_valid), .err_code(err_code),
  .commit_evt(commit_evt), .lat_held(lat_held),
  .both_rise(both_rise), .hold_short(hold_short)
);

// File: tb/eeprom_seq_ctrl_test.sv
module eeprom_seq_ctrl_test;
  localparam int HOLD = 64;
  localparam logic [7:0] B_PGM = 8'h01, B_LAT = 8'h02, B_ERASE = 8'h04,
                         B_ROW = 8'h08, B_BYTE = 8'h10;
  localparam int K_ERR = 0, K_RD = 1, K_CTRL = 2, K_CFG = 3, K_MAP = 4;

  logic clk = 1'b0;
  logic pwr_rst_n = 1'b0, rst_n = 1'b0;
  logic reg_we = 1'b0, reg_sel = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic mem_we = 1'b0, mem_re = 1'b0;
  logic [5:0] mem_addr = 6'd0;
  logic [7:0] mem_wdata = 8'h00;
  logic [7:0] ctrl_q, cfg_q, mem_rdata;
  logic mem_mapped, err_valid;
  logic [2:0] err_code;

  int checks = 0, failures = 0;
  bit done = 0;

  typedef struct { int kind; int exp; string tag; } item_t;
  item_t exp_q[$];

  always #5 clk = ~clk;

  eeprom_seq_ctrl #(.HOLD_MIN(HOLD)) uut (
    .clk(clk), .pwr_rst_n(pwr_rst_n), .rst_n(rst_n),
    .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .ctrl_q(ctrl_q), .cfg_q(cfg_q),
    .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .mem_mapped(mem_mapped),
    .err_valid(err_valid), .err_code(err_code)
  );

  task automatic expect_item(int kind, int exp, string tag);
    item_t it;
    it.kind = kind; it.exp = exp; it.tag = tag;
    exp_q.push_back(it);
  endtask

  // monitor: compares queued expectations just after each falling edge
  initial forever begin
    @(negedge clk);
    #1;
    while (exp_q.size() > 0) begin
      item_t it;
      int act;
      it = exp_q.pop_front();
      case (it.kind)
        K_ERR:   act = err_valid ? int'(err_code) : 0;
        K_RD:    act = int'(mem_rdata);
        K_CTRL:  act = int'(ctrl_q);
        K_CFG:   act = int'(cfg_q);
        default: act = int'(mem_mapped);
      endcase
      checks++;
      if (act != it.exp) begin
        failures++;
        $display("FAIL %s kind=%0d actual=%0h expected=%0h", it.tag, it.kind, act, it.exp);
      end
    end
  end

  // every access task starts and ends on a falling edge
  task automatic ctrl_write(logic [7:0] v, int exp_err, string tag);
    reg_we = 1'b1; reg_sel = 1'b0; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0;
    expect_item(K_ERR, exp_err, tag);
  endtask

  task automatic cfg_write(logic [7:0] v, int exp_err, string tag);
    reg_we = 1'b1; reg_sel = 1'b1; reg_wdata = v;
    @(negedge clk);
    reg_we = 1'b0; reg_sel = 1'b0;
    expect_item(K_ERR, exp_err, tag);
  endtask

  task automatic mem_write(int a, logic [7:0] d, int exp_err, string tag);
    mem_we = 1'b1; mem_addr = 6'(a); mem_wdata = d;
    @(negedge clk);
    mem_we = 1'b0;
    expect_item(K_ERR, exp_err, tag);
  endtask

  task automatic mem_read(int a, int exp_data, int exp_err, string tag);
    mem_re = 1'b1; mem_addr = 6'(a);
    expect_item(K_RD, exp_data, tag);
    @(negedge clk);
    mem_re = 1'b0;
    expect_item(K_ERR, exp_err, tag);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // voltage on, hold for 'elapsed' edges, voltage off with mode bits kept
  task automatic hv(logic [7:0] mode, int elapsed, int on_err, int off_err, string tag);
    ctrl_write(mode | B_LAT | B_PGM, on_err, tag);
    idle(elapsed - 1);
    ctrl_write(mode | B_LAT, off_err, tag);
  endtask

  task automatic program_byte(int a, logic [7:0] d, int elapsed, string tag);
    ctrl_write(B_LAT, 0, tag);
    mem_write(a, d, 0, tag);
    hv(8'h00, elapsed, 0, (elapsed < HOLD) ? 3 : 0, tag);
    ctrl_write(8'h00, 0, tag);
  endtask

  task automatic rst_pulse();
    rst_n = 1'b0;
    idle(2);
    rst_n = 1'b1;
  endtask

  initial begin
    idle(3);
    pwr_rst_n = 1'b1;
    idle(2);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    expect_item(K_CTRL, 0, "R1 ctrl");
    expect_item(K_CFG, 'hFF, "R1 cfg");
    expect_item(K_MAP, 1, "R1 mapped");
    mem_read(5, 'hFF, 0, "R1 erased array");

    // R3 both on from idle
    ctrl_write(8'h03, 1, "R3 both on");
    expect_item(K_CTRL, 0, "R3 unchanged");
    idle(1);
    expect_item(K_ERR, 0, "R14 pulse one cycle");

    // R2 register shape
    ctrl_write(8'hE2, 0, "R2");
    expect_item(K_CTRL, 'h02, "R2 upper bits zero");
    ctrl_write(8'h1C, 0, "R2");
    expect_item(K_CTRL, 0, "R2 latch off clears");

    // R6 not armed
    mem_write(5, 8'h00, 4, "R6 not armed");
    mem_read(5, 'hFF, 0, "R6 nothing stored");

    // R6 double latch, R7 read while armed, R8 program
    ctrl_write(B_LAT, 0, "R8");
    mem_write(5, 8'hA5, 0, "R8 latch");
    mem_write(5, 8'h00, 5, "R6 double latch");
    mem_read(5, 'hFF, 6, "R7 read armed");
    hv(8'h00, HOLD, 0, 0, "R5 exact hold");
    ctrl_write(8'h00, 0, "R8");
    mem_read(5, 'hA5, 0, "R8 first pair kept");
    program_byte(5, 8'h3C, HOLD, "R8");
    mem_read(5, 'h24, 0, "R8 AND into cell");
    program_byte(6, 8'h0F, HOLD, "R8");
    program_byte(20, 8'h11, HOLD, "R8");
    program_byte(40, 8'h22, HOLD - 1, "R5 short hold");
    mem_read(40, 'h22, 0, "R5 commit despite short");

    // R4 voltage with nothing latched
    ctrl_write(B_LAT, 0, "R4");
    ctrl_write(B_LAT | B_PGM, 2, "R4 no address");
    idle(HOLD - 1);
    ctrl_write(8'h00, 0, "R3 clear both");
    mem_read(5, 'h24, 0, "R4 nothing committed");

    // R9 byte erase
    ctrl_write(B_BYTE | B_ERASE | B_LAT, 0, "R9");
    mem_write(5, 8'h00, 0, "R9");
    hv(B_BYTE | B_ERASE, HOLD, 0, 0, "R9");
    ctrl_write(8'h00, 0, "R9");
    mem_read(5, 'hFF, 0, "R9 byte erased");
    mem_read(6, 'h0F, 0, "R9 neighbour kept");

    // R10 row erase, address 21 -> row 16..31
    ctrl_write(B_ROW | B_ERASE | B_LAT, 0, "R10");
    mem_write(21, 8'h00, 0, "R10");
    hv(B_ROW | B_ERASE, HOLD, 0, 0, "R10");
    ctrl_write(8'h00, 0, "R10");
    mem_read(20, 'hFF, 0, "R10 row erased");
    mem_read(6, 'h0F, 0, "R10 other row kept");
    mem_read(40, 'h22, 0, "R10 other row kept");

    // R12 program configuration, deferred until reset
    ctrl_write(B_LAT, 0, "R12");
    cfg_write(8'hFE, 0, "R12 cfg latch");
    hv(8'h00, HOLD, 0, 0, "R12");
    ctrl_write(8'h00, 0, "R12");
    expect_item(K_CFG, 'hFF, "R12 not before reset");
    expect_item(K_MAP, 1, "R12 not before reset");
    rst_pulse();
    expect_item(K_CFG, 'hFE, "R12 after reset");
    expect_item(K_MAP, 0, "R1 unmapped by cfg");
    expect_item(K_CTRL, 0, "R1 ctrl cleared");

    // R13 unmapped access
    mem_read(40, 0, 0, "R13 unmapped read");
    ctrl_write(B_ERASE | B_LAT, 0, "R13");
    mem_write(6, 8'h00, 0, "R13 write ignored");
    cfg_write(8'h00, 0, "R13 nothing latched before");
    // erase at cfg address with no byte/row bit: single byte only (R12)
    hv(B_ERASE, HOLD, 0, 0, "R12 cfg erase");
    ctrl_write(8'h00, 0, "R12");
    rst_pulse();
    expect_item(K_CFG, 'hFF, "R12 cfg erased");
    expect_item(K_MAP, 1, "R12 remapped");
    mem_read(40, 'h22, 0, "R12 not bulk");
    mem_read(6, 'h0F, 0, "R13 write had no effect");

    // R11 bulk erase includes configuration byte
    ctrl_write(B_LAT, 0, "R11");
    cfg_write(8'hFE, 0, "R11");
    hv(8'h00, HOLD, 0, 0, "R11");
    ctrl_write(8'h00, 0, "R11");
    ctrl_write(B_ERASE | B_LAT, 0, "R11");
    mem_write(6, 8'h00, 0, "R11");
    hv(B_ERASE, HOLD, 0, 0, "R11");
    ctrl_write(8'h00, 0, "R11");
    mem_read(6, 'hFF, 0, "R11 bulk");
    mem_read(40, 'hFF, 0, "R11 bulk");
    mem_read(5, 'hFF, 0, "R11 bulk");
    rst_pulse();
    expect_item(K_CFG, 'hFF, "R11 cfg erased by bulk");
    expect_item(K_MAP, 1, "R11 mapped");

    idle(3);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #1ms;
    if (!done) begin
      done = 1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule